// File: doc/BRIEF.md
# Indirect Interrupt Routing Register Front End

This block is the bus-facing register file of an I/O interrupt routing controller. Software sees only two words on a small bus: a select register and a data window. The value in the select register picks one register in a larger internal space, and accesses to the window reach that register. The internal space holds three things. The first is a 4-bit controller identifier. The second is a read-only word that reports the version code and the number of pins. The third is a table with one 64-bit routing entry per interrupt pin. Each entry is reached as two 32-bit halves.

Every routing entry is stored in flops, so that all of its fields reach the delivery logic in parallel. The block brings out each entry's vector, delivery mode, destination mode, trigger mode, mask, remote-IRR status and destination. It also gives a one-cycle pulse after every entry write, and a separate pulse, carrying the pin and the new mask value, whenever a write flips an entry's mask. The delivery logic sets an entry's remote-IRR status through a per-pin set input. Software can only clear that status, as a side effect of writing the low half of the entry. Interrupt delivery and end-of-interrupt handling sit outside this block.

Top module: `irq_route_regs`

## Requirements
- R1: Bus offset 0x00 is the 8-bit select register (a write stores wdata[7:0], a read returns it zero-extended) and offset 0x10 is the data window. A read of any other offset returns 0, and a write to any other offset changes nothing.
- R2: Select value 0x01 reads the version word: NUM_PINS-1 in bits 23:16, VERSION_CODE in bits 7:0, and zeros elsewhere. A window write at this select value has no effect.
- R3: Select value 0x00 reads the identifier in bits 27:24 and zeros elsewhere; a window write there loads wdata[27:24]. Select value 0x02 reads the same word, and window writes at 0x02 are ignored.
- R4: For select values of 0x10 and above, the table index is (select-0x10)>>1. An even select value reaches entry bits 31:0 and an odd one reaches bits 63:32. A write changes only the addressed half of the addressed entry.
- R5: A table index at or above NUM_PINS, and any select value from 0x03 to 0x0F, reads 0xFFFFFFFF. Window writes there are dropped, and no entry-write pulse is given.
- R6: A window write to the low half of an entry clears that entry's remote-IRR bit (bit 14) whatever value is written. A write to the high half leaves the bit unchanged. The bus can never set it.
- R7: A pulse on rirr_set[i] sets entry i's remote-IRR bit. When it falls in the same cycle as a low-half write to entry i, the set wins.
- R8: After reset, every entry reads 0x00010000 in its low half (mask set) and 0 in its high half, and the select register, the identifier and rd_data are all 0.
- R9: Entry layout: vector 7:0, delivery mode 10:8, destination mode 11, delivery status 12, polarity 13, remote IRR 14, trigger mode 15, mask 16, destination 63:56. The exported per-pin field ports follow the stored entry.
- R10: In the cycle after a table write is accepted, ent_wr_pulse is 1, with ent_wr_idx giving the pin and ent_wr_hi giving the half (1 = bits 63:32).
- R11: In the cycle after a low-half write that changes an entry's mask bit, mask_chg_pulse is 1, with mask_chg_idx giving the pin and mask_chg_val giving the new mask. A write that leaves the mask unchanged gives no pulse.
- R12: rd_data is loaded at the clock edge where rd_en is high and holds its value at all other edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| bus_addr | input | 8 | Bus byte offset |
| wr_data | input | 32 | Bus write data |
| rd_data | output | 32 | Registered read data |
| rirr_set | input | NUM_PINS | Per-pin remote-IRR set from delivery logic |
| ent_vector | output | NUM_PINS*8 | Vector of each entry |
| ent_dlv_mode | output | NUM_PINS*3 | Delivery mode of each entry |
| ent_dst_mode | output | NUM_PINS | Destination mode of each entry |
| ent_trig | output | NUM_PINS | Trigger mode of each entry |
| ent_mask | output | NUM_PINS | Mask of each entry |
| ent_rirr | output | NUM_PINS | Remote-IRR status of each entry |
| ent_dest | output | NUM_PINS*8 | Destination of each entry |
| ent_wr_pulse | output | 1 | An entry half was written |
| ent_wr_idx | output | IDX_W | Pin of the written entry |
| ent_wr_hi | output | 1 | Written half was bits 63:32 |
| mask_chg_pulse | output | 1 | A write changed a mask bit |
| mask_chg_idx | output | IDX_W | Pin whose mask changed |
| mask_chg_val | output | 1 | New mask value |

## Verification
Two things can change the remote-IRR bit of the same entry in one cycle: a software write to the entry's low half, which clears it, and a set pulse from the delivery logic. The bench drives a low-half window write and rirr_set for that pin in the same cycle, then reads the entry back through the window and requires bit 14 to be set. It also checks the cases on either side of that collision. A set pulse on its own must show up in the read-back. A later low-half write with bit 14 high in its data must clear the bit. A high-half write must leave it alone.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;

  localparam logic [7:0] OFF_SELECT = 8'h00;
  localparam logic [7:0] OFF_WINDOW = 8'h10;
  localparam logic [7:0] SEL_IDENT  = 8'h00;
  localparam logic [7:0] SEL_VERS   = 8'h01;
  localparam logic [7:0] SEL_ARBIT  = 8'h02;
  localparam logic [7:0] SEL_TABLE  = 8'h10;

  typedef enum logic [2:0] {
    ACC_IDENT,
    ACC_VERS,
    ACC_ARBIT,
    ACC_TABLE,
    ACC_VOID
  } acc_kind_e;

  typedef struct packed {
    logic [7:0]  dest;
    logic [38:0] rsvd;
    logic        mask;
    logic        trig;
    logic        rirr;
    logic        polarity;
    logic        dlv_stat;
    logic        dst_mode;
    logic [2:0]  dlv_mode;
    logic [7:0]  vector;
  } route_entry_t;

  localparam route_entry_t ENTRY_RESET = '{mask: 1'b1, default: '0};

  function automatic logic [6:0] table_index(input logic [7:0] sel);
    logic [7:0] off;
    off = sel - SEL_TABLE;
    return off[7:1];
  endfunction

  function automatic logic [31:0] version_word(input int pins, input logic [7:0] code);
    logic [7:0] cap;
    cap = 8'(pins - 1);
    return {8'h00, cap, 8'h00, code};
  endfunction

endpackage

// File: rtl/irq_sel_decode.sv
module irq_sel_decode
  import irq_regs_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [7:0]      bus_addr,
  input  logic [31:0]     wr_data,
  output logic [7:0]      sel_q,
  output acc_kind_e       acc_kind,
  output logic [6:0]      tbl_idx,
  output logic            tbl_hi,
  output logic            id_we,
  output logic            tbl_we,
  output logic [NUM_PINS-1:0] we_lo,
  output logic [NUM_PINS-1:0] we_hi
);

  logic sel_we;
  logic win_wr;
  logic in_range;

  assign sel_we = wr_en && (bus_addr == OFF_SELECT);
  assign win_wr = wr_en && (bus_addr == OFF_WINDOW);

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= '0;
    else if (sel_we) sel_q <= wr_data[7:0];
  end

  assign tbl_idx  = table_index(sel_q);
  assign tbl_hi   = sel_q[0];
  assign in_range = (sel_q >= SEL_TABLE) && (int'(tbl_idx) < NUM_PINS);

  always_comb begin
    if (sel_q == SEL_IDENT)      acc_kind = ACC_IDENT;
    else if (sel_q == SEL_VERS)  acc_kind = ACC_VERS;
    else if (sel_q == SEL_ARBIT) acc_kind = ACC_ARBIT;
    else if (in_range)           acc_kind = ACC_TABLE;
    else                         acc_kind = ACC_VOID;
  end

  assign id_we  = win_wr && (acc_kind == ACC_IDENT);
  assign tbl_we = win_wr && (acc_kind == ACC_TABLE);

  for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_we
    assign we_lo[gi] = tbl_we && !tbl_hi && (int'(tbl_idx) == gi);
    assign we_hi[gi] = tbl_we &&  tbl_hi && (int'(tbl_idx) == gi);
  end

  AST_SEL_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> $past(wr_en && (bus_addr == OFF_SELECT))); // R1

  AST_ONE_HALF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({we_lo, we_hi})); // R4

endmodule

// File: rtl/irq_route_entry.sv
module irq_route_entry
  import irq_regs_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_lo,
  input  logic         we_hi,
  input  logic [31:0]  wr_data,
  input  logic         rirr_set,
  output route_entry_t ent_q,
  output logic         mask_chg
);

  route_entry_t nxt;

  always_comb begin
    nxt = ent_q;
    if (we_lo) begin
      nxt[31:0] = wr_data;
      nxt.rirr  = 1'b0;
    end
    if (we_hi) nxt[63:32] = wr_data;
    if (rirr_set) nxt.rirr = 1'b1;
  end

  assign mask_chg = we_lo && (wr_data[16] != ent_q.mask);

  always_ff @(posedge clk) begin
    if (!rst_n) ent_q <= ENTRY_RESET;
    else        ent_q <= nxt;
  end

  AST_RIRR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (we_lo && !rirr_set) |=> !ent_q.rirr); // R6

  AST_RIRR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    rirr_set |=> ent_q.rirr); // R7

  AST_MASK_ONLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ent_q.mask) |-> $past(we_lo)); // R11

  AST_HI_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (we_hi && !rirr_set) |=> $stable(ent_q[31:0])); // R4

endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux
  import irq_regs_pkg::*;
#(
  parameter int         NUM_PINS     = 24,
  parameter logic [7:0] VERSION_CODE = 8'h11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_en,
  input  logic [7:0]   bus_addr,
  input  logic [7:0]   sel_q,
  input  acc_kind_e    acc_kind,
  input  logic [6:0]   tbl_idx,
  input  logic         tbl_hi,
  input  logic [3:0]   id_q,
  input  route_entry_t ents [NUM_PINS],
  output logic [31:0]  rd_data
);

  logic [31:0]  win_word;
  logic [31:0]  rd_next;
  route_entry_t pick;

  always_comb begin
    pick = ents[0];
    for (int i = 0; i < NUM_PINS; i++)
      if (int'(tbl_idx) == i) pick = ents[i];
  end

  always_comb begin
    unique case (acc_kind)
      ACC_IDENT, ACC_ARBIT: win_word = {4'h0, id_q, 24'h0};
      ACC_VERS:             win_word = version_word(NUM_PINS, VERSION_CODE);
      ACC_TABLE:            win_word = tbl_hi ? pick[63:32] : pick[31:0];
      default:              win_word = '1;
    endcase
  end

  always_comb begin
    if (bus_addr == OFF_SELECT)      rd_next = {24'h0, sel_q};
    else if (bus_addr == OFF_WINDOW) rd_next = win_word;
    else                             rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R12

endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_regs_pkg::*;
#(
  parameter int         NUM_PINS     = 24,
  parameter logic [7:0] VERSION_CODE = 8'h11,
  localparam int        IDX_W        = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [7:0]            bus_addr,
  input  logic [31:0]           wr_data,
  output logic [31:0]           rd_data,
  input  logic [NUM_PINS-1:0]   rirr_set,
  output logic [NUM_PINS*8-1:0] ent_vector,
  output logic [NUM_PINS*3-1:0] ent_dlv_mode,
  output logic [NUM_PINS-1:0]   ent_dst_mode,
  output logic [NUM_PINS-1:0]   ent_trig,
  output logic [NUM_PINS-1:0]   ent_mask,
  output logic [NUM_PINS-1:0]   ent_rirr,
  output logic [NUM_PINS*8-1:0] ent_dest,
  output logic                  ent_wr_pulse,
  output logic [IDX_W-1:0]      ent_wr_idx,
  output logic                  ent_wr_hi,
  output logic                  mask_chg_pulse,
  output logic [IDX_W-1:0]      mask_chg_idx,
  output logic                  mask_chg_val
);

  logic [7:0]          sel_q;
  acc_kind_e           acc_kind;
  logic [6:0]          tbl_idx;
  logic                tbl_hi;
  logic                id_we;
  logic                tbl_we;
  logic [NUM_PINS-1:0] we_lo;
  logic [NUM_PINS-1:0] we_hi;
  logic [NUM_PINS-1:0] mask_chg_vec;
  logic [3:0]          id_q;
  route_entry_t        ents [NUM_PINS];

  irq_sel_decode #(.NUM_PINS(NUM_PINS)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .bus_addr (bus_addr),
    .wr_data  (wr_data),
    .sel_q    (sel_q),
    .acc_kind (acc_kind),
    .tbl_idx  (tbl_idx),
    .tbl_hi   (tbl_hi),
    .id_we    (id_we),
    .tbl_we   (tbl_we),
    .we_lo    (we_lo),
    .we_hi    (we_hi)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     id_q <= '0;
    else if (id_we) id_q <= wr_data[27:24];
  end

  for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_ent
    irq_route_entry u_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_lo    (we_lo[gi]),
      .we_hi    (we_hi[gi]),
      .wr_data  (wr_data),
      .rirr_set (rirr_set[gi]),
      .ent_q    (ents[gi]),
      .mask_chg (mask_chg_vec[gi])
    );
    assign ent_vector[gi*8 +: 8]   = ents[gi].vector;
    assign ent_dlv_mode[gi*3 +: 3] = ents[gi].dlv_mode;
    assign ent_dst_mode[gi]        = ents[gi].dst_mode;
    assign ent_trig[gi]            = ents[gi].trig;
    assign ent_mask[gi]            = ents[gi].mask;
    assign ent_rirr[gi]            = ents[gi].rirr;
    assign ent_dest[gi*8 +: 8]     = ents[gi].dest;
  end

  irq_rd_mux #(.NUM_PINS(NUM_PINS), .VERSION_CODE(VERSION_CODE)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .bus_addr (bus_addr),
    .sel_q    (sel_q),
    .acc_kind (acc_kind),
    .tbl_idx  (tbl_idx),
    .tbl_hi   (tbl_hi),
    .id_q     (id_q),
    .ents     (ents),
    .rd_data  (rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_wr_pulse   <= 1'b0;
      ent_wr_idx     <= '0;
      ent_wr_hi      <= 1'b0;
      mask_chg_pulse <= 1'b0;
      mask_chg_idx   <= '0;
      mask_chg_val   <= 1'b0;
    end else begin
      ent_wr_pulse   <= tbl_we;
      mask_chg_pulse <= |mask_chg_vec;
      if (tbl_we) begin
        ent_wr_idx   <= tbl_idx[IDX_W-1:0];
        ent_wr_hi    <= tbl_hi;
        mask_chg_idx <= tbl_idx[IDX_W-1:0];
        mask_chg_val <= wr_data[16];
      end
    end
  end

  AST_ID_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(id_q) |-> $past(id_we)); // R3

  AST_MASK_EVT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    mask_chg_pulse |-> (ent_mask[mask_chg_idx] == mask_chg_val)); // R11

  AST_MASK_EVT_HAS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mask_chg_pulse |-> (ent_wr_pulse && !ent_wr_hi)); // R10

endmodule

// File: tb/test_irq_route_regs.sv
module test_irq_route_regs;

  localparam int PINS  = 24;
  localparam int IW    = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic            rd_en = 1'b0;
  logic [7:0]      bus_addr = '0;
  logic [31:0]     wr_data = '0;
  logic [31:0]     rd_data;
  logic [PINS-1:0] rirr_set = '0;
  logic [PINS*8-1:0] ent_vector, ent_dest;
  logic [PINS*3-1:0] ent_dlv_mode;
  logic [PINS-1:0] ent_dst_mode, ent_trig, ent_mask, ent_rirr;
  logic            ent_wr_pulse, ent_wr_hi, mask_chg_pulse, mask_chg_val;
  logic [IW-1:0]   ent_wr_idx, mask_chg_idx;

  int n_checks = 0;
  int n_errors = 0;
  logic        seen_wr, seen_hi, seen_mc, seen_mval;
  logic [IW-1:0] seen_widx, seen_midx;

  always #5 clk = ~clk;

  irq_route_regs i_irq_route_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .bus_addr(bus_addr), .wr_data(wr_data), .rd_data(rd_data),
    .rirr_set(rirr_set), .ent_vector(ent_vector), .ent_dlv_mode(ent_dlv_mode),
    .ent_dst_mode(ent_dst_mode), .ent_trig(ent_trig), .ent_mask(ent_mask),
    .ent_rirr(ent_rirr), .ent_dest(ent_dest), .ent_wr_pulse(ent_wr_pulse),
    .ent_wr_idx(ent_wr_idx), .ent_wr_hi(ent_wr_hi),
    .mask_chg_pulse(mask_chg_pulse), .mask_chg_idx(mask_chg_idx),
    .mask_chg_val(mask_chg_val)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; bus_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    seen_wr = ent_wr_pulse; seen_hi = ent_wr_hi; seen_widx = ent_wr_idx;
    seen_mc = mask_chg_pulse; seen_mval = mask_chg_val; seen_midx = mask_chg_idx;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic win_rd(input logic [7:0] s, output logic [31:0] d);
    bus_wr(8'h00, {24'h0, s});
    bus_rd(8'h10, d);
  endtask

  task automatic win_wr(input logic [7:0] s, input logic [31:0] d);
    bus_wr(8'h00, {24'h0, s});
    bus_wr(8'h10, d);
  endtask

  function automatic logic [7:0] lo_sel(input int pin);
    return 8'(8'h10 + 2 * pin);
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    chk("R8 rd_data after reset", rd_data, 32'h0);
    chk("R8 all masks set", {8'h0, ent_mask}, {8'h0, {PINS{1'b1}}});
    bus_rd(8'h00, v);
    chk("R8 select reset", v, 32'h0);
    bus_rd(8'h10, v);
    chk("R8 ident reset", v, 32'h0);
    win_rd(lo_sel(7), v);
    chk("R8 entry low reset", v, 32'h0001_0000);
    win_rd(lo_sel(7) + 8'd1, v);
    chk("R8 entry high reset", v, 32'h0);
  endtask

  task automatic t_offsets();
    logic [31:0] v;
    bus_wr(8'h00, 32'h0000_01A5);
    bus_rd(8'h00, v);
    chk("R1 select keeps 8 bits", v, 32'h0000_00A5);
    bus_rd(8'h20, v);
    chk("R1 other offset reads zero", v, 32'h0);
    bus_wr(8'h04, 32'h0000_0033);
    bus_rd(8'h00, v);
    chk("R1 other offset write ignored", v, 32'h0000_00A5);
  endtask

  task automatic t_version();
    logic [31:0] v;
    logic [31:0] exp;
    exp = ((PINS - 1) << 16) | 32'h11;
    win_rd(8'h01, v);
    chk("R2 version word", v, exp);
    bus_wr(8'h10, 32'hFFFF_FFFF);
    bus_rd(8'h10, v);
    chk("R2 version write no effect", v, exp);
  endtask

  task automatic t_ident();
    logic [31:0] v;
    win_wr(8'h00, 32'hA5FF_FFFF);
    bus_rd(8'h10, v);
    chk("R3 ident field only", v, 32'h0500_0000);
    win_rd(8'h02, v);
    chk("R3 arbitration mirrors ident", v, 32'h0500_0000);
    bus_wr(8'h10, 32'h0300_0000);
    win_rd(8'h00, v);
    chk("R3 arbitration write ignored", v, 32'h0500_0000);
  endtask

  task automatic t_fields();
    logic [31:0] v;
    logic [31:0] lo;
    lo = 32'h31 | (32'd1 << 8) | (32'd1 << 11) | (32'd1 << 13) | (32'd1 << 15);
    win_wr(lo_sel(3), lo);
    chk("R10 write pulse low", {seen_wr, seen_hi, 3'b0, seen_widx}, {1'b1, 1'b0, 3'b0, 5'd3});
    chk("R11 mask cleared pulse", {seen_mc, seen_mval, 3'b0, seen_midx}, {1'b1, 1'b0, 3'b0, 5'd3});
    bus_rd(8'h10, v);
    chk("R4 low half readback", v, lo);
    bus_wr(8'h00, {24'h0, lo_sel(3) + 8'd1});
    bus_wr(8'h10, 32'h7E00_0000);
    chk("R10 write pulse high", {seen_wr, seen_hi, 3'b0, seen_widx}, {1'b1, 1'b1, 3'b0, 5'd3});
    chk("R11 no pulse on high write", {31'h0, seen_mc}, 32'h0);
    bus_rd(8'h10, v);
    chk("R4 high half readback", v, 32'h7E00_0000);
    win_rd(lo_sel(2), v);
    chk("R4 neighbour untouched", v, 32'h0001_0000);
    chk("R9 vector port", {24'h0, ent_vector[3*8 +: 8]}, 32'h31);
    chk("R9 delivery mode port", {29'h0, ent_dlv_mode[3*3 +: 3]}, 32'h1);
    chk("R9 dst mode trig mask", {29'h0, ent_dst_mode[3], ent_trig[3], ent_mask[3]}, 32'b110);
    chk("R9 destination port", {24'h0, ent_dest[3*8 +: 8]}, 32'h7E);
    win_wr(lo_sel(3), lo);
    chk("R11 unchanged mask no pulse", {30'h0, seen_wr, seen_mc}, 32'b10);
    win_wr(lo_sel(3), lo | (32'd1 << 16));
    chk("R11 mask set pulse", {30'h0, seen_mc, seen_mval}, 32'b11);
    win_wr(lo_sel(3), lo);
  endtask

  task automatic t_range();
    logic [31:0] v;
    win_wr(lo_sel(PINS - 1), 32'h0000_0042);
    chk("R5 last pin accepted", {27'h0, seen_wr, seen_widx[3:0]}, {27'h0, 1'b1, 4'(PINS - 1)});
    chk("R9 last pin vector", {24'h0, ent_vector[(PINS-1)*8 +: 8]}, 32'h42);
    win_rd(lo_sel(PINS), v);
    chk("R5 first missing pin reads ones", v, 32'hFFFF_FFFF);
    bus_wr(8'h10, 32'h0);
    chk("R5 dropped write no pulse", {31'h0, seen_wr}, 32'h0);
    chk("R5 masks unchanged", {8'h0, ent_mask}, {8'h0, {PINS{1'b1}} & ~(24'd1 << 3) & ~(24'd1 << (PINS-1))});
    win_rd(8'h05, v);
    chk("R5 gap select reads ones", v, 32'hFFFF_FFFF);
    win_rd(8'hFF, v);
    chk("R5 top select reads ones", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_rirr();
    logic [31:0] v;
    logic [31:0] lo;
    lo = 32'h0000_A931;
    @(negedge clk); rirr_set[3] = 1'b1;
    @(negedge clk); rirr_set[3] = 1'b0;
    win_rd(lo_sel(3), v);
    chk("R7 set pulse sets bit 14", v, lo | 32'h4000);
    bus_wr(8'h00, {24'h0, lo_sel(3) + 8'd1});
    bus_wr(8'h10, 32'h7E00_0000);
    chk("R6 high write keeps remote bit", {31'h0, ent_rirr[3]}, 32'h1);
    win_wr(lo_sel(3), lo | 32'h4000);
    bus_rd(8'h10, v);
    chk("R6 low write clears remote bit", v, lo);
    @(negedge clk);
    wr_en = 1'b1; bus_addr = 8'h10; wr_data = lo; rirr_set[3] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rirr_set[3] = 1'b0;
    bus_rd(8'h10, v);
    chk("R7 set wins over low write", v, lo | 32'h4000);
  endtask

  task automatic t_hold();
    logic [31:0] v;
    logic [31:0] first;
    win_rd(8'h01, first);
    bus_wr(8'h00, 32'h0000_0005);
    @(negedge clk);
    chk("R12 rd_data holds without read", rd_data, first);
    bus_rd(8'h10, v);
    chk("R12 read updates", v, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_offsets();
    t_version();
    t_ident();
    t_fields();
    t_range();
    t_rirr();
    t_hold();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule